// File: doc/BRIEF.md
# Multi-Channel Thermal Sampling Sequencer

This block runs periodic sampling rounds over up to three temperature-sensor channels that share a single ADC. A period timer, counted in units of 4096 clocks, starts each round. Within a round the sequencer visits the enabled channels from the lowest index upward. For each channel it waits a programmable acquire time, sends a one-cycle start strobe to the ADC with the channel number, and then waits for the ADC's valid strobe. The 12-bit result either goes straight into that channel's data register or feeds a per-channel averager. The averager publishes only once its power-of-two window is full.

Software reaches the block through a plain word-addressed write port and a combinational read port. Each time a channel's data register is written, a per-channel ready flag in a status register is set. Software clears these flags by writing ones to them. If every enable bit is cleared, no further rounds start, and the stored results stay in place.

The sequencer has four states. In `SEQ_IDLE` it waits for a period tick; a tick with any channel enabled latches the enable mask, selects the lowest enabled channel and moves to `SEQ_ACQUIRE`. `SEQ_ACQUIRE` counts N+1 clocks and then moves to `SEQ_KICK`. `SEQ_KICK` drives the ADC start strobe for one cycle and always moves on to `SEQ_WAIT`. `SEQ_WAIT` holds until the ADC valid strobe arrives. On that strobe it goes back to `SEQ_ACQUIRE` if a higher enabled channel remains in the latched mask, and to `SEQ_IDLE` if none does.

Top module: `tsq_top`

## Requirements
- R1: After reset every register reads zero: control 0x40, period 0x44, status 0x48, filter 0x70 and data 0x80/0x84/0x88. `adc_start` stays low.
- R2: While any channel is enabled, consecutive rounds start exactly 4096*(P+1) clocks apart. P is the 20-bit field in bits 31:12 of the period register at 0x44.
- R3: The acquire time N is held in control bits 31:16. Between the clock edge that accepts one channel's `adc_valid` and the next `adc_start` of the same round there are N+1 acquire clocks. Sampled at falling edges, the start is seen exactly N+2 cycles after the valid.
- R4: Control bits 0, 1 and 2 enable channels 0, 1 and 2. A round converts only the enabled channels, in ascending index order, and reports the index on `adc_chan`. A disabled channel adds no acquire time.
- R5: A result is taken only on an `adc_valid` that follows a start. With the filter off (filter bit 2 clear), each result is written to bits 11:0 of its channel's data register at 0x80 + 4*channel. Data registers change only on an accepted result.
- R6: When filter bit 2 is set, filter bits 1:0 give n and the window is 2^(n+1) samples. The data register stays unchanged until the window is full. It then receives the sum of the window's samples shifted right by n+1.
- R7: Any write to the filter register discards the partial windows of all channels. The data registers and their values are kept.
- R8: Publishing a channel's value sets status bit 8+channel. Writing ones to status bits 10:8 clears those bits and leaves the others as they were.
- R9: With all enable bits cleared, no `adc_start` occurs, and the data registers keep their last values.
- R10: `adc_start` is a single-cycle pulse. `adc_chan` holds its value from the start until the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| adc_valid | input | 1 | ADC result valid strobe |
| adc_code | input | 12 | ADC raw result |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_chan | output | 2 | Channel being converted |

## Verification
A wrong channel pointer or enable mask in the state machine shows up on `adc_chan` at the next start strobe, within N+2 cycles of the previous result. A miscounted acquire counter moves that strobe by the same number of cycles. A fault in the period timer shifts when the next round starts, so it is visible one period later. A corrupted accumulator or window counter stays hidden until that channel's window closes; only then does a wrong value or a missing ready flag appear. For that reason the bench reads every data register and the status register after each round, so a fault is caught no later than the end of the first full window.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACQUIRE = 2'd1,
        SEQ_KICK    = 2'd2,
        SEQ_WAIT    = 2'd3
    } seq_state_t;

    localparam logic [7:0] ADDR_CTRL   = 8'h40;
    localparam logic [7:0] ADDR_PERIOD = 8'h44;
    localparam logic [7:0] ADDR_STATUS = 8'h48;
    localparam logic [7:0] ADDR_FILTER = 8'h70;
    localparam logic [7:0] ADDR_DATA0  = 8'h80;

    localparam int CTRL_ACQ_LSB = 16;
    localparam int PER_LSB      = 12;
    localparam int RDY_LSB      = 8;
endpackage

// File: rtl/tsq_timer.sv
module tsq_timer #(
    parameter int UNIT  = 4096,
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] per_p,
    output logic             tick
);
    localparam int UW = $clog2(UNIT);

    logic [UW-1:0]    unit_cnt;
    logic [PER_W-1:0] per_cnt;
    logic             unit_end;

    assign unit_end = (unit_cnt == UW'(UNIT - 1));
    assign tick     = run && unit_end && (per_cnt >= per_p);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            unit_cnt <= '0;
            per_cnt  <= '0;
        end else if (unit_end) begin
            unit_cnt <= '0;
            per_cnt  <= (per_cnt >= per_p) ? '0 : per_cnt + 1'b1;
        end else begin
            unit_cnt <= unit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
    import tsq_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int ACQ_W = 16,
    parameter int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCH-1:0]   en,
    input  logic [ACQ_W-1:0] acq_n,
    input  logic             adc_valid,
    output logic             adc_start,
    output logic [CW-1:0]    adc_chan,
    output logic             take,
    output logic [NCH-1:0]   round_mask
);
    seq_state_t       st, st_nxt;
    logic [CW-1:0]    ch;
    logic [ACQ_W-1:0] acq_cnt;
    logic [NCH-1:0]   mask_q;
    logic [CW:0]      first_hit, next_hit;

    // lowest set bit of m at or above index 'from'; MSB of result = found
    function automatic logic [CW:0] pick(input logic [NCH-1:0] m, input logic [CW:0] from);
        logic [CW:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && ((CW+1)'(i) >= from)) r = {1'b1, CW'(i)};
        end
        return r;
    endfunction

    assign first_hit = pick(en, '0);
    assign next_hit  = pick(mask_q, {1'b0, ch} + (CW+1)'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEQ_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SEQ_IDLE:    if (tick && (|en)) st_nxt = SEQ_ACQUIRE;
            SEQ_ACQUIRE: if (acq_cnt == acq_n) st_nxt = SEQ_KICK;
            SEQ_KICK:    st_nxt = SEQ_WAIT;
            SEQ_WAIT:    if (adc_valid) st_nxt = next_hit[CW] ? SEQ_ACQUIRE : SEQ_IDLE;
            default:     st_nxt = SEQ_IDLE;
        endcase
    end

    always_comb begin
        adc_start  = (st == SEQ_KICK);
        take       = (st == SEQ_WAIT) && adc_valid;
        adc_chan   = ch;
        round_mask = mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch      <= '0;
            acq_cnt <= '0;
            mask_q  <= '0;
        end else if (st == SEQ_IDLE && tick && (|en)) begin
            mask_q  <= en;
            ch      <= first_hit[CW-1:0];
            acq_cnt <= '0;
        end else if (st == SEQ_ACQUIRE) begin
            acq_cnt <= acq_cnt + 1'b1;
        end else if (take) begin
            acq_cnt <= '0;
            if (next_hit[CW]) ch <= next_hit[CW-1:0];
        end
    end
endmodule

// File: rtl/tsq_avg.sv
module tsq_avg #(
    parameter int NCH    = 3,
    parameter int CODE_W = 12,
    parameter int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [CW-1:0]         ch,
    input  logic [CODE_W-1:0]     code,
    input  logic                  fen,
    input  logic [1:0]            fn,
    input  logic                  clr,
    output logic [NCH*CODE_W-1:0] data_flat,
    output logic [NCH-1:0]        pub
);
    localparam int AW = CODE_W + 4;

    logic [4:0] win_last;
    logic [2:0] shamt;

    assign win_last = (5'd2 << fn) - 5'd1;
    assign shamt    = {1'b0, fn} + 3'd1;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [AW-1:0]     acc;
        logic [3:0]        cnt;
        logic [CODE_W-1:0] data;
        logic [AW-1:0]     sum;
        logic              mine, full;

        assign mine = take && (ch == CW'(i));
        assign full = ({1'b0, cnt} == win_last);
        assign sum  = acc + AW'(code);
        assign pub[i] = mine && (!fen || full);
        assign data_flat[i*CODE_W +: CODE_W] = data;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc  <= '0;
                cnt  <= '0;
                data <= '0;
            end else if (clr) begin
                acc <= '0;
                cnt <= '0;
            end else if (mine) begin
                if (!fen) begin
                    data <= code;
                end else if (full) begin
                    data <= CODE_W'(sum >> shamt);
                    acc  <= '0;
                    cnt  <= '0;
                end else begin
                    acc <= sum;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsq_regs.sv
module tsq_regs
    import tsq_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CODE_W = 12,
    parameter int ACQ_W  = 16,
    parameter int PER_W  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [7:0]            addr,
    input  logic [31:0]           wdata,
    input  logic [NCH-1:0]        pub,
    input  logic [NCH*CODE_W-1:0] data_flat,
    output logic [31:0]           rdata,
    output logic [NCH-1:0]        en,
    output logic [ACQ_W-1:0]      acq_n,
    output logic [PER_W-1:0]      per_p,
    output logic                  fen,
    output logic [1:0]            fn,
    output logic                  filt_wr,
    output logic [NCH-1:0]        rdy
);
    logic [NCH-1:0] clr_mask;
    logic           unused_wdata;

    assign unused_wdata = ^wdata;
    assign filt_wr  = wr && (addr == ADDR_FILTER);
    assign clr_mask = (wr && addr == ADDR_STATUS) ? wdata[RDY_LSB +: NCH] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= '0;
            acq_n <= '0;
            per_p <= '0;
            fen   <= 1'b0;
            fn    <= '0;
            rdy   <= '0;
        end else begin
            rdy <= (rdy & ~clr_mask) | pub;
            if (wr && addr == ADDR_CTRL) begin
                en    <= wdata[NCH-1:0];
                acq_n <= wdata[CTRL_ACQ_LSB +: ACQ_W];
            end
            if (wr && addr == ADDR_PERIOD) per_p <= wdata[PER_LSB +: PER_W];
            if (filt_wr) begin
                fen <= wdata[2];
                fn  <= wdata[1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL:   rdata = 32'(en) | (32'(acq_n) << CTRL_ACQ_LSB);
            ADDR_PERIOD: rdata = 32'(per_p) << PER_LSB;
            ADDR_STATUS: rdata = 32'(rdy) << RDY_LSB;
            ADDR_FILTER: rdata = {29'd0, fen, fn};
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == 8'(ADDR_DATA0 + 8'(4 * i)))
                        rdata = 32'(data_flat[i*CODE_W +: CODE_W]);
                end
            end
        endcase
    end
endmodule

// File: rtl/tsq_top.sv
module tsq_top #(
    parameter int NCH    = 3,
    parameter int CODE_W = 12,
    parameter int ACQ_W  = 16,
    parameter int PER_W  = 20,
    parameter int UNIT   = 4096,
    parameter int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    output logic              adc_start,
    output logic [CW-1:0]     adc_chan
);
    logic [NCH-1:0]        en, rdy, pub, round_mask;
    logic [ACQ_W-1:0]      acq_n;
    logic [PER_W-1:0]      per_p;
    logic                  fen, filt_wr, tick, take;
    logic [1:0]            fn;
    logic [NCH*CODE_W-1:0] data_flat;

    tsq_regs #(.NCH(NCH), .CODE_W(CODE_W), .ACQ_W(ACQ_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .pub(pub), .data_flat(data_flat), .rdata(reg_rdata), .en(en), .acq_n(acq_n),
        .per_p(per_p), .fen(fen), .fn(fn), .filt_wr(filt_wr), .rdy(rdy)
    );

    tsq_timer #(.UNIT(UNIT), .PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(|en), .per_p(per_p), .tick(tick)
    );

    tsq_seq #(.NCH(NCH), .ACQ_W(ACQ_W), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .acq_n(acq_n),
        .adc_valid(adc_valid), .adc_start(adc_start), .adc_chan(adc_chan),
        .take(take), .round_mask(round_mask)
    );

    tsq_avg #(.NCH(NCH), .CODE_W(CODE_W), .CW(CW)) u_avg (
        .clk(clk), .rst_n(rst_n), .take(take), .ch(adc_chan), .code(adc_code),
        .fen(fen), .fn(fn), .clr(filt_wr), .data_flat(data_flat), .pub(pub)
    );
endmodule

// File: rtl/tsq_chk.sv
module tsq_chk #(
    parameter int NCH    = 3,
    parameter int CODE_W = 12,
    parameter int CW     = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  adc_start,
    input logic                  adc_valid,
    input logic [CW-1:0]         adc_chan,
    input logic [NCH-1:0]        round_mask,
    input logic [NCH-1:0]        rdy,
    input logic [NCH*CODE_W-1:0] data_flat
);
    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    assert_chan_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ((round_mask >> adc_chan) & NCH'(1)) != '0);

    assert_ready_from_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rdy & ~$past(rdy))) |-> $past(adc_valid));

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_valid |=> $stable(data_flat));
endmodule

bind tsq_top tsq_chk #(.NCH(NCH), .CODE_W(CODE_W), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_valid(adc_valid),
    .adc_chan(adc_chan), .round_mask(round_mask), .rdy(rdy), .data_flat(data_flat)
);

// File: tb/tsq_top_tb.sv
`timescale 1ns/1ps
module tsq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_code = '0;
    logic        adc_start;
    logic [1:0]  adc_chan;

    int checks = 0;
    int errors = 0;

    tsq_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_valid(adc_valid),
        .adc_code(adc_code), .adc_start(adc_start), .adc_chan(adc_chan)
    );

    always #2.5 clk = ~clk;

    // expected model, built from the requirements
    int       m_data [3];
    int       m_sum  [3];
    int       m_cnt  [3];
    bit [2:0] m_rdy;
    bit       m_fen;
    int       m_fn;
    bit [2:0] cur_mask;
    int       cur_n;

    int  nsamp [3];
    int  total = 0, nstart = 0;
    int  cyc = 0, last_valid = 0, last_start = -100000;
    int  rs_prev = 0, rs_last = 0;
    int  pend_cnt = 0, pend_ch = 0, prev_ch = 0;
    bit  prev_start = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int code_of(input int ch, input int k);
        return (ch * 1300 + k * 517 + 91) % 4096;
    endfunction

    task automatic model_take(input int ch, input int code);
        if (!m_fen) begin
            m_data[ch] = code;
            m_rdy[ch]  = 1'b1;
        end else begin
            m_sum[ch] += code;
            m_cnt[ch]++;
            if (m_cnt[ch] == (2 << m_fn)) begin
                m_data[ch] = m_sum[ch] >> (m_fn + 1);
                m_sum[ch]  = 0;
                m_cnt[ch]  = 0;
                m_rdy[ch]  = 1'b1;
            end
        end
    endtask

    function automatic int first_from(input bit [2:0] m, input int from);
        for (int i = from; i < 3; i++) if (m[i]) return i;
        return -1;
    endfunction

    // ADC model and sequencing monitor
    always @(negedge clk) begin
        cyc++;
        adc_valid = 1'b0;
        if (rst_n) begin
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    chk(adc_chan == 2'(pend_ch), "R10", "adc_chan held until result", int'(adc_chan), pend_ch);
                    adc_code  = 12'(code_of(pend_ch, nsamp[pend_ch]));
                    adc_valid = 1'b1;
                    model_take(pend_ch, int'(adc_code));
                    nsamp[pend_ch]++;
                    total++;
                    last_valid = cyc;
                    prev_ch    = pend_ch;
                end
            end
            if (adc_start) begin
                int exp_ch;
                nstart++;
                chk(!prev_start, "R10", "start is one cycle", int'(prev_start), 0);
                if (cyc - last_start > 1000) begin
                    exp_ch  = first_from(cur_mask, 0);
                    rs_prev = rs_last;
                    rs_last = cyc;
                end else begin
                    exp_ch = first_from(cur_mask, prev_ch + 1);
                    chk(cyc - last_valid == cur_n + 2, "R3", "valid-to-start gap", cyc - last_valid, cur_n + 2);
                end
                chk(int'(adc_chan) == exp_ch, "R4", "channel order", int'(adc_chan), exp_ch);
                last_start = cyc;
                pend_ch    = int'(adc_chan);
                pend_cnt   = 2;
            end
        end
        prev_start = adc_start;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 8'h40) begin cur_mask = d[2:0]; cur_n = int'(d[31:16]); end
        if (a == 8'h48) m_rdy = m_rdy & ~d[10:8];
        if (a == 8'h70) begin
            m_fen = d[2]; m_fn = int'(d[1:0]);
            for (int i = 0; i < 3; i++) begin m_sum[i] = 0; m_cnt[i] = 0; end
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic verify(input string req);
        int v;
        rd(8'h48, v);
        chk(v == (int'(m_rdy) << 8), req, "status flags", v, int'(m_rdy) << 8);
        for (int i = 0; i < 3; i++) begin
            rd(8'(8'h80 + 4 * i), v);
            chk(v == m_data[i], req, $sformatf("data ch%0d", i), v, m_data[i]);
        end
    endtask

    task automatic run(input int n);
        int tgt;
        tgt = total + n;
        while (total < tgt) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int s;
        for (int i = 0; i < 3; i++) begin
            m_data[i] = 0; m_sum[i] = 0; m_cnt[i] = 0; nsamp[i] = 0;
        end
        m_rdy = '0; m_fen = 1'b0; m_fn = 0; cur_mask = '0; cur_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(!adc_start, "R1", "adc_start after reset", int'(adc_start), 0);
        rd(8'h40, v); chk(v == 0, "R1", "control", v, 0);
        rd(8'h44, v); chk(v == 0, "R1", "period", v, 0);
        rd(8'h48, v); chk(v == 0, "R1", "status", v, 0);
        rd(8'h70, v); chk(v == 0, "R1", "filter", v, 0);
        for (int i = 0; i < 3; i++) begin
            rd(8'(8'h80 + 4 * i), v); chk(v == 0, "R1", "data", v, 0);
        end

        // R5/R2/R8: raw publish, three channels, N=3, P=0
        wr(8'h70, 32'h0);
        wr(8'h40, (32'd3 << 16) | 32'h7);
        run(3);
        verify("R5");
        run(3);
        verify("R5");
        chk(rs_last - rs_prev == 4096, "R2", "round spacing P=0", rs_last - rs_prev, 4096);
        wr(8'h48, 32'h100);
        rd(8'h48, v); chk(v == 32'h600, "R8", "partial clear", v, 32'h600);
        wr(8'h48, 32'h700);
        rd(8'h48, v); chk(v == 0, "R8", "full clear", v, 0);

        // R6: window of 4, data held until full
        wr(8'h70, 32'h5);
        for (int r = 0; r < 5; r++) begin
            run(3);
            verify("R6");
            wr(8'h48, 32'h700);
        end

        // R4/R6: channel 1 skipped, N=9, window of 8
        wr(8'h40, (32'd9 << 16) | 32'h5);
        wr(8'h70, 32'h6);
        for (int r = 0; r < 8; r++) begin
            run(2);
            verify("R6");
            wr(8'h48, 32'h700);
        end

        // R7/R2: window of 2, period P=1, partial window discarded
        wr(8'h44, 32'd1 << 12);
        wr(8'h40, (32'd2 << 16) | 32'h3);
        wr(8'h70, 32'h4);
        run(2);
        verify("R7");
        wr(8'h70, 32'h4);
        run(2);
        verify("R7");
        run(2);
        verify("R7");
        chk(rs_last - rs_prev == 8192, "R2", "round spacing P=1", rs_last - rs_prev, 8192);
        wr(8'h48, 32'h700);

        // R9: stop with all enables clear
        wr(8'h40, 32'h0);
        s = nstart;
        repeat (3 * 4096 + 200) @(negedge clk);
        chk(nstart == s, "R9", "no starts when disabled", nstart, s);
        verify("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule